// File: doc/BRIEF.md
# XON/XOFF Software Flow Controller

This unit sits beside a UART and handles in-band software flow control. On the receive side it checks every received character against four programmable control codes: two resume codes and two stop codes. A stop code pauses the local transmitter and a resume code releases it. Control characters that match are removed from the receive data stream. Every other character is passed through one cycle later.

On the transmit side it watches the receive FIFO fill level. It asks the transmitter to send a stop code when the fill reaches a programmable halt level. Once the FIFO has drained to a programmable resume level, it asks for a resume code. The receive-side compare and the transmit-side generation are configured separately. Each can use the first code set, the second set, or both, in which case the two codes form a pair. The pause output changes only while the transmitter sits between characters, so a character already being sent is never cut short. Framing, baud timing and the FIFO itself are outside this block.

Top module: `swflow_ctrl`

## Requirements
- R1: When `en_i` is low, nothing is compared, every character is forwarded, no detect flag rises, no send request is made and the pause state is cleared.
- R2: With receive mode `mode_i[1:0]`=10, only set 1 is compared. Receiving XON1 releases the transmitter and receiving XOFF1 pauses it. XON2 and XOFF2 are forwarded as data.
- R3: With receive mode 01, only set 2 is compared. Receiving XON2 releases the transmitter and receiving XOFF2 pauses it. XON1 and XOFF1 are forwarded as data.
- R4: With receive mode 11, all four codes are compared. XOFF1 immediately followed by XOFF2 pauses, and XON1 immediately followed by XON2 releases. A first code alone, or a pair broken by another character, changes nothing.
- R5: `det_o` pulses for one cycle, one cycle after a compared code arrives. Its bits are 0 = XON1, 1 = XON2, 2 = XOFF1 and 3 = XOFF2, and only codes in the compared set raise a bit.
- R6: A character that matches a compared code is not forwarded. Any other received character appears on `fwd_valid_o`/`fwd_data_o` one cycle after its strobe.
- R7: `pause_o` only changes on a clock edge where `tx_idle_i` is high. A pause or release requested while the transmitter is busy takes effect at its next idle cycle.
- R8: `level_thr_i[3:0]` is the halt level and `level_thr_i[7:4]` is the resume level, both in units of 8 FIFO words. When the FIFO level reaches halt×8, a single one-cycle request to send the stop code is made, and it is not repeated while the level stays high.
- R9: After a stop request, once the FIFO level is at or below resume×8, a single request to send the resume code is made.
- R10: Transmit mode `mode_i[3:2]` selects the codes sent. With 10 it sends XOFF1/XON1 and with 01 it sends XOFF2/XON2. With 11 it sends XOFF1 then XOFF2 (or XON1 then XON2) as requests on two consecutive cycles.
- R11: With transmit mode 00, or with a halt field of zero, no send request is made at any FIFO level.
- R12: With receive mode 00, no code is compared, no detect flag rises and the transmitter is never paused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Master software flow-control enable |
| mode_i | input | 4 | [1:0] receive compare mode, [3:2] transmit generation mode |
| xon1_i | input | 8 | Resume code, set 1 |
| xon2_i | input | 8 | Resume code, set 2 |
| xoff1_i | input | 8 | Stop code, set 1 |
| xoff2_i | input | 8 | Stop code, set 2 |
| level_thr_i | input | 8 | [3:0] halt level, [7:4] resume level, units of 8 words |
| rx_valid_i | input | 1 | Received character strobe |
| rx_data_i | input | 8 | Received character |
| rx_level_i | input | 8 | Receive FIFO fill level, 0 to 128 |
| tx_idle_i | input | 1 | Transmitter is between characters |
| pause_o | output | 1 | Hold off the transmitter |
| send_req_o | output | 1 | One-cycle request to send a control code |
| send_code_o | output | 8 | Code to send, valid with send_req_o |
| det_o | output | 4 | Special-character detect pulses |
| fwd_valid_o | output | 1 | Forwarded character strobe |
| fwd_data_o | output | 8 | Forwarded character |

## Verification
The bench breaks a two-code pair with an ordinary character. A design that keeps only the most recent pending code without checking adjacency would still pause or release on that broken pair. It also sends a stop code while the transmitter is busy: a design that passes pause through at once would cut a character short, so the bench holds `tx_idle_i` low and expects `pause_o` unchanged. The FIFO level is held above the halt level and then walked just past each threshold (31/32 against a halt level of 32, 17/16 against a resume level of 16). A design without one-shot behaviour would repeat its request, and an off-by-one compare would fire a cycle early or not at all. Codes of the set that is not compared are fed in and expected to be forwarded. A design that compares all four codes in a single-set mode would drop them and raise flags.

// File: rtl/swf_pkg.sv
package swf_pkg;
  localparam int CODE_W = 8;
  localparam int N_CODES = 4;
  // detect bit positions
  localparam int IDX_ON1  = 0;
  localparam int IDX_ON2  = 1;
  localparam int IDX_OFF1 = 2;
  localparam int IDX_OFF2 = 3;

  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_ON1  = 2'd1,
    PEND_OFF1 = 2'd2
  } pend_e;
endpackage

// File: rtl/swf_rx_match.sv
module swf_rx_match
  import swf_pkg::*;
#(
  parameter int CW = CODE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [1:0]    cmp_mode_i,
  input  logic [CW-1:0] xon1_i,
  input  logic [CW-1:0] xon2_i,
  input  logic [CW-1:0] xoff1_i,
  input  logic [CW-1:0] xoff2_i,
  input  logic          rx_valid_i,
  input  logic [CW-1:0] rx_data_i,
  output logic [N_CODES-1:0] det_o,
  output logic          fwd_valid_o,
  output logic [CW-1:0] fwd_data_o,
  output logic          xon_evt_o,
  output logic          xoff_evt_o
);
  logic [N_CODES-1:0][CW-1:0] codes;
  logic [N_CODES-1:0]         hit;
  logic                       single1, single2, both;
  pend_e                      pend_q, pend_d;

  assign codes[IDX_ON1]  = xon1_i;
  assign codes[IDX_ON2]  = xon2_i;
  assign codes[IDX_OFF1] = xoff1_i;
  assign codes[IDX_OFF2] = xoff2_i;

  // odd indices belong to set 2, even to set 1
  for (genvar i = 0; i < N_CODES; i++) begin : g_cmp
    localparam int SEL = (i % 2 == 1) ? 0 : 1;
    assign hit[i] = en_i && rx_valid_i && cmp_mode_i[SEL] && (rx_data_i == codes[i]);
  end

  assign single1 = (cmp_mode_i == 2'b10);
  assign single2 = (cmp_mode_i == 2'b01);
  assign both    = (cmp_mode_i == 2'b11);

  always_comb begin
    xoff_evt_o = (single1 && hit[IDX_OFF1]) ||
                 (single2 && hit[IDX_OFF2]) ||
                 (both && pend_q == PEND_OFF1 && hit[IDX_OFF2]);
    xon_evt_o  = ((single1 && hit[IDX_ON1]) ||
                  (single2 && hit[IDX_ON2]) ||
                  (both && pend_q == PEND_ON1 && hit[IDX_ON2])) && !xoff_evt_o;
  end

  always_comb begin
    pend_d = pend_q;
    if (!en_i || !both) pend_d = PEND_NONE;
    else if (rx_valid_i) begin
      if (hit[IDX_ON1])       pend_d = PEND_ON1;
      else if (hit[IDX_OFF1]) pend_d = PEND_OFF1;
      else                    pend_d = PEND_NONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= PEND_NONE;
      det_o       <= '0;
      fwd_valid_o <= 1'b0;
      fwd_data_o  <= '0;
    end else begin
      pend_q      <= pend_d;
      det_o       <= hit;
      fwd_valid_o <= rx_valid_i && (hit == '0);
      if (rx_valid_i) fwd_data_o <= rx_data_i;
    end
  end
endmodule

// File: rtl/swf_tx_gen.sv
module swf_tx_gen #(
  parameter int CW    = 8,
  parameter int LVL_W = 8,
  parameter int THR_W = 4,
  parameter int UNIT  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       gen_mode_i,
  input  logic [THR_W-1:0] halt_i,
  input  logic [THR_W-1:0] resume_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [CW-1:0]    xon1_i,
  input  logic [CW-1:0]    xon2_i,
  input  logic [CW-1:0]    xoff1_i,
  input  logic [CW-1:0]    xoff2_i,
  output logic             req_o,
  output logic [CW-1:0]    code_o
);
  localparam int CMP_W = LVL_W + THR_W + $clog2(UNIT) + 1;

  logic [CMP_W-1:0] lvl_ext, halt_lvl, res_lvl;
  logic             active, pair;
  logic             halted_q, sec_q;
  logic [CW-1:0]    sec_code_q;
  logic [CW-1:0]    off_first, on_first;

  assign lvl_ext  = CMP_W'(level_i);
  assign halt_lvl = CMP_W'(halt_i) * CMP_W'(UNIT);
  assign res_lvl  = CMP_W'(resume_i) * CMP_W'(UNIT);
  assign active   = en_i && (gen_mode_i != 2'b00) && (halt_i != '0);
  assign pair     = (gen_mode_i == 2'b11);
  assign off_first = gen_mode_i[1] ? xoff1_i : xoff2_i;
  assign on_first  = gen_mode_i[1] ? xon1_i  : xon2_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halted_q   <= 1'b0;
      sec_q      <= 1'b0;
      sec_code_q <= '0;
      req_o      <= 1'b0;
      code_o     <= '0;
    end else if (!active) begin
      halted_q <= 1'b0;
      sec_q    <= 1'b0;
      req_o    <= 1'b0;
    end else if (sec_q) begin
      req_o  <= 1'b1;
      code_o <= sec_code_q;
      sec_q  <= 1'b0;
    end else if (!halted_q && lvl_ext >= halt_lvl) begin
      req_o      <= 1'b1;
      code_o     <= off_first;
      halted_q   <= 1'b1;
      sec_q      <= pair;
      sec_code_q <= xoff2_i;
    end else if (halted_q && lvl_ext <= res_lvl) begin
      req_o      <= 1'b1;
      code_o     <= on_first;
      halted_q   <= 1'b0;
      sec_q      <= pair;
      sec_code_q <= xon2_i;
    end else begin
      req_o <= 1'b0;
    end
  end
endmodule

// File: rtl/swf_pause_gate.sv
module swf_pause_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic cmp_on_i,
  input  logic xon_evt_i,
  input  logic xoff_evt_i,
  input  logic tx_idle_i,
  output logic pause_o
);
  logic stop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_q  <= 1'b0;
      pause_o <= 1'b0;
    end else begin
      if (!en_i || !cmp_on_i) stop_q <= 1'b0;
      else if (xoff_evt_i)    stop_q <= 1'b1;
      else if (xon_evt_i)     stop_q <= 1'b0;
      // only move at a character boundary
      if (tx_idle_i) pause_o <= stop_q;
    end
  end
endmodule

// File: rtl/swflow_ctrl.sv
module swflow_ctrl
  import swf_pkg::*;
#(
  parameter int FIFO_DEPTH = 128,
  parameter int THR_UNIT   = 8,
  parameter int THR_W      = 4,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [3:0]        mode_i,
  input  logic [CODE_W-1:0] xon1_i,
  input  logic [CODE_W-1:0] xon2_i,
  input  logic [CODE_W-1:0] xoff1_i,
  input  logic [CODE_W-1:0] xoff2_i,
  input  logic [2*THR_W-1:0] level_thr_i,
  input  logic              rx_valid_i,
  input  logic [CODE_W-1:0] rx_data_i,
  input  logic [LVL_W-1:0]  rx_level_i,
  input  logic              tx_idle_i,
  output logic              pause_o,
  output logic              send_req_o,
  output logic [CODE_W-1:0] send_code_o,
  output logic [N_CODES-1:0] det_o,
  output logic              fwd_valid_o,
  output logic [CODE_W-1:0] fwd_data_o
);
  logic xon_evt, xoff_evt;

  swf_rx_match #(.CW(CODE_W)) u_rx (
    .clk_i, .rst_ni, .en_i,
    .cmp_mode_i (mode_i[1:0]),
    .xon1_i, .xon2_i, .xoff1_i, .xoff2_i,
    .rx_valid_i, .rx_data_i,
    .det_o, .fwd_valid_o, .fwd_data_o,
    .xon_evt_o  (xon_evt),
    .xoff_evt_o (xoff_evt)
  );

  swf_pause_gate u_gate (
    .clk_i, .rst_ni, .en_i,
    .cmp_on_i   (mode_i[1:0] != 2'b00),
    .xon_evt_i  (xon_evt),
    .xoff_evt_i (xoff_evt),
    .tx_idle_i,
    .pause_o
  );

  swf_tx_gen #(.CW(CODE_W), .LVL_W(LVL_W), .THR_W(THR_W), .UNIT(THR_UNIT)) u_tx (
    .clk_i, .rst_ni, .en_i,
    .gen_mode_i (mode_i[3:2]),
    .halt_i     (level_thr_i[THR_W-1:0]),
    .resume_i   (level_thr_i[2*THR_W-1:THR_W]),
    .level_i    (rx_level_i),
    .xon1_i, .xon2_i, .xoff1_i, .xoff2_i,
    .req_o      (send_req_o),
    .code_o     (send_code_o)
  );
endmodule

// File: rtl/swflow_ctrl_chk.sv
module swflow_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic [3:0] mode_i,
  input logic       tx_idle_i,
  input logic       pause_o,
  input logic       send_req_o,
  input logic [3:0] det_o,
  input logic       fwd_valid_o
);
  // R7
  pause_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_idle_i |=> $stable(pause_o));

  // R6
  drop_matched_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (det_o != 4'b0000) |-> !fwd_valid_o);

  // R1
  master_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (det_o == 4'b0000) && !send_req_o);

  // R12
  rx_cmp_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i[1:0] == 2'b00) |=> (det_o == 4'b0000));

  // R10
  req_burst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_req_o && $past(send_req_o)) |=> !send_req_o);
endmodule

bind swflow_ctrl swflow_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .mode_i      (mode_i),
  .tx_idle_i   (tx_idle_i),
  .pause_o     (pause_o),
  .send_req_o  (send_req_o),
  .det_o       (det_o),
  .fwd_valid_o (fwd_valid_o)
);

// File: tb/sim_swflow_ctrl.sv
`timescale 1ns/1ps
module sim_swflow_ctrl;
  localparam logic [7:0] ON1 = 8'h11, ON2 = 8'h21, OFF1 = 8'h13, OFF2 = 8'h23;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b1;
  logic [3:0] mode_i = 4'b0000;
  logic [7:0] level_thr_i = 8'h00;
  logic       rx_valid_i = 1'b0;
  logic [7:0] rx_data_i = 8'h00;
  logic [7:0] rx_level_i = 8'd0;
  logic       tx_idle_i = 1'b1;
  logic       pause_o, send_req_o, fwd_valid_o;
  logic [7:0] send_code_o, fwd_data_o;
  logic [3:0] det_o;

  int n_chk = 0, n_fail = 0;
  logic [3:0] s_det;
  logic       s_fv;
  logic [7:0] s_fd;

  always #10 clk_i = ~clk_i;

  swflow_ctrl u0 (
    .clk_i, .rst_ni, .en_i, .mode_i,
    .xon1_i(ON1), .xon2_i(ON2), .xoff1_i(OFF1), .xoff2_i(OFF2),
    .level_thr_i, .rx_valid_i, .rx_data_i, .rx_level_i, .tx_idle_i,
    .pause_o, .send_req_o, .send_code_o, .det_o, .fwd_valid_o, .fwd_data_o
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic settle(); @(negedge clk_i); endtask

  task automatic rx_char(input logic [7:0] d);
    @(negedge clk_i);
    rx_valid_i = 1'b1; rx_data_i = d;
    @(negedge clk_i);
    rx_valid_i = 1'b0;
    s_det = det_o; s_fv = fwd_valid_o; s_fd = fwd_data_o;
  endtask

  task automatic set_level(input logic [7:0] l);
    @(negedge clk_i);
    rx_level_i = l;
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    chk("R7 reset pause", pause_o, 0);
    chk("R8 reset req", send_req_o, 0);
    chk("R5 reset det", det_o, 0);
    chk("R6 reset fwd", fwd_valid_o, 0);
  endtask

  task automatic t_rx_set1();
    mode_i = 4'b0010;
    rx_char(OFF1);
    chk("R5 det xoff1 bit2", s_det, 4'b0100);
    chk("R6 xoff1 dropped", s_fv, 0);
    settle();
    chk("R2 xoff1 pauses", pause_o, 1);
    rx_char(ON2);
    chk("R2 xon2 forwarded", {s_fv, s_fd}, {1'b1, ON2});
    chk("R5 xon2 uncompared", s_det, 0);
    settle();
    chk("R2 xon2 no release", pause_o, 1);
    rx_char(ON1);
    chk("R5 det xon1 bit0", s_det, 4'b0001);
    settle();
    chk("R2 xon1 releases", pause_o, 0);
    rx_char(8'h41);
    chk("R6 data forwarded", {s_fv, s_fd}, {1'b1, 8'h41});
  endtask

  task automatic t_rx_set2();
    mode_i = 4'b0001;
    rx_char(OFF1);
    chk("R3 xoff1 forwarded", {s_fv, s_fd, s_det}, {1'b1, OFF1, 4'b0000});
    settle();
    chk("R3 xoff1 no pause", pause_o, 0);
    rx_char(OFF2);
    chk("R5 det xoff2 bit3", s_det, 4'b1000);
    settle();
    chk("R3 xoff2 pauses", pause_o, 1);
    rx_char(ON2);
    chk("R5 det xon2 bit1", s_det, 4'b0010);
    settle();
    chk("R3 xon2 releases", pause_o, 0);
  endtask

  task automatic t_rx_both();
    mode_i = 4'b0011;
    rx_char(OFF1);
    chk("R4 xoff1 flagged dropped", {s_fv, s_det}, {1'b0, 4'b0100});
    settle();
    chk("R4 lone xoff1 no pause", pause_o, 0);
    rx_char(OFF2);
    settle();
    chk("R4 xoff pair pauses", pause_o, 1);
    rx_char(ON1);
    rx_char(8'h55);
    chk("R4 breaker forwarded", {s_fv, s_fd}, {1'b1, 8'h55});
    rx_char(ON2);
    settle();
    chk("R4 broken pair no release", pause_o, 1);
    rx_char(ON1);
    rx_char(ON2);
    settle();
    chk("R4 xon pair releases", pause_o, 0);
  endtask

  task automatic t_boundary();
    mode_i = 4'b0010;
    tx_idle_i = 1'b0;
    rx_char(OFF1);
    repeat (4) settle();
    chk("R7 busy holds pause low", pause_o, 0);
    tx_idle_i = 1'b1;
    settle();
    chk("R7 idle applies pause", pause_o, 1);
    tx_idle_i = 1'b0;
    rx_char(ON1);
    repeat (3) settle();
    chk("R7 busy holds pause high", pause_o, 1);
    tx_idle_i = 1'b1;
    settle();
    chk("R7 idle applies release", pause_o, 0);
  endtask

  task automatic t_enable();
    mode_i = 4'b1010;
    level_thr_i = 8'h24;
    rx_char(OFF1);
    settle();
    chk("R2 pause before disable", pause_o, 1);
    en_i = 1'b0;
    rx_char(OFF1);
    chk("R1 off forwards", {s_fv, s_fd, s_det}, {1'b1, OFF1, 4'b0000});
    settle();
    chk("R1 off clears pause", pause_o, 0);
    rx_level_i = 8'd100;
    repeat (3) begin
      settle();
      chk("R1 off no request", send_req_o, 0);
    end
    rx_level_i = 8'd0;
    settle();
    en_i = 1'b1;
    mode_i = 4'b0000;
  endtask

  task automatic t_rx_off();
    mode_i = 4'b0000;
    rx_char(OFF2);
    chk("R12 no compare", {s_fv, s_det}, {1'b1, 4'b0000});
    settle();
    chk("R12 no pause", pause_o, 0);
  endtask

  task automatic t_tx(input logic [1:0] tm, input logic [7:0] c_off, input logic [7:0] c_on,
                      input string tag);
    mode_i = {tm, 2'b00};
    level_thr_i = 8'h24;  // halt 32, resume 16
    set_level(8'd0);
    set_level(8'd31);
    chk({tag, " R8 below halt"}, send_req_o, 0);
    set_level(8'd32);
    chk({tag, " R8 xoff req"}, {send_req_o, send_code_o}, {1'b1, c_off});
    settle();
    if (tm == 2'b11) begin
      chk({tag, " R10 xoff2 second"}, {send_req_o, send_code_o}, {1'b1, OFF2});
      settle();
    end
    chk({tag, " R8 one-shot"}, send_req_o, 0);
    set_level(8'd40);
    chk({tag, " R8 no repeat"}, send_req_o, 0);
    set_level(8'd17);
    chk({tag, " R9 above resume"}, send_req_o, 0);
    set_level(8'd16);
    chk({tag, " R9 xon req"}, {send_req_o, send_code_o}, {1'b1, c_on});
    settle();
    if (tm == 2'b11) begin
      chk({tag, " R10 xon2 second"}, {send_req_o, send_code_o}, {1'b1, ON2});
      settle();
    end
    chk({tag, " R9 one-shot"}, send_req_o, 0);
  endtask

  task automatic t_tx_off();
    mode_i = 4'b1000;
    level_thr_i = 8'h20;  // halt 0
    for (int l = 0; l <= 128; l += 16) begin
      set_level(l[7:0]);
      chk("R11 halt zero no req", send_req_o, 0);
    end
    mode_i = 4'b0000;
    level_thr_i = 8'h24;
    set_level(8'd0);
    set_level(8'd64);
    chk("R11 mode00 no req", send_req_o, 0);
    set_level(8'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    settle();
    t_reset();
    t_rx_set1();
    t_rx_set2();
    t_rx_both();
    t_boundary();
    t_enable();
    t_rx_off();
    t_tx(2'b10, OFF1, ON1, "set1");
    t_tx(2'b01, OFF2, ON2, "set2");
    t_tx(2'b11, OFF1, ON1, "both");
    t_tx_off();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule